// File: doc/BRIEF.md
# Transmit Slew-Rate Calibration Sequencer

This block runs one calibration of a transmitter's edge rate each time it sees a start pulse. It powers an on-die ring oscillator, lets it settle, turns on a free-running clock for a frequency meter, and loads the meter with a 1024-cycle measurement window and a channel number equal to the requested port. It then arms the meter and checks the meter's valid flag at fixed intervals. If the flag never comes, it gives up after a bounded number of intervals.

Once the count is taken, the sequencer first stops the meter and then the free-running clock. It turns the count into a 3-bit slew code by two divisions. The first is an integer division of a fixed constant (window × reference MHz × 28) by the count. The second divides that result by 1000 with rounding to nearest. A zero count falls back to a default code, and any result above the field maximum is clamped. The code register is written, the oscillator is switched off, and a one-cycle done pulse closes the run.

All waits are counted in reference-clock cycles. Their defaults assume a 26 MHz clock: 1 µs to settle, 10 µs between polls and a 200 µs limit. The meter and the analog circuits lie outside the block.

Top module: `srcal_seq`

## Requirements
- R1: After reset, oscillator enable, free-run clock enable, meter enable and done are low, and the code output holds the default value 4.
- R2: A run first raises the oscillator enable and holds it for at least OSC_WAIT_CYC cycles before the free-run clock enable rises. The meter enable rises only while both enables are high, and at that moment the window output already reads 1024 and the channel output equals the port sampled with start.
- R3: While the meter is armed, the valid flag is sampled once per poll interval of POLL_CYC cycles, and the count is taken at the first sample that finds valid high.
- R4: If valid is not seen within TIMEOUT_CYC/POLL_CYC intervals, the sequence still continues and uses whatever count is present on the count input at that time.
- R5: The meter enable falls strictly before the free-run clock enable falls. The new code is written before the oscillator enable falls.
- R6: For a nonzero count C, the code is round-to-nearest(floor(745472 / C) / 1000), where halves round up.
- R7: A count of zero gives code 4.
- R8: A computed code above 7 is written as 7.
- R9: Done is high for exactly one cycle per run, in the same cycle the oscillator enable falls. A start that arrives during a run is ignored: it changes neither the channel nor the number of done pulses.
- R10: The code output changes only in the write step of a run. Between runs it holds its value whatever the meter inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins one calibration run |
| port_i | input | PORT_W | Port to measure, sampled with start |
| done_o | output | 1 | One-cycle pulse when a run ends |
| osc_en_o | output | 1 | Ring-oscillator enable |
| frck_en_o | output | 1 | Free-running meter clock enable |
| meter_en_o | output | 1 | Frequency-meter enable |
| meter_win_o | output | WIN_W | Measurement window length in cycles |
| meter_chan_o | output | PORT_W | Meter channel select |
| meter_valid_i | input | 1 | Meter result valid |
| meter_count_i | input | CNT_W | Meter count result |
| code_o | output | CODE_W | Slew code register |

## Verification
On every cycle, the assertions check the interlocks between the enables. The meter runs only under both the oscillator and the free-run clock. Its window and channel are already set when it arms, and the clock outlives the meter. They also check that done is a single pulse falling together with the oscillator, that the code register changes only in its write step, that the poll counter stays within bounds, and that the divider's remainder stays below the divisor. Only the bench scenarios can show the numerical result of the two divisions: rounding at the half boundary, the clamp, the zero fallback, the position of a timeout relative to the poll intervals, and the refusal of a start that comes mid-run.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_OSCW,
      S_PROG,
      S_ARM,
      S_POLL,
      S_MOFF,
      S_FOFF,
      S_DIV,
      S_WRITE,
      S_OSCOFF
   } srcal_st_e;

   function automatic int unsigned srcal_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/srcal_tmr.sv
module srcal_tmr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   if (W < 1) begin : g_bad_w
      $error("srcal_tmr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
   parameter int unsigned NW = 20,
   parameter int unsigned DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [NW-1:0] numer_i,
   input  logic [DW-1:0] denom_i,
   output logic [NW-1:0] quo_o,
   output logic          ready_o
);
   localparam int unsigned CW = $clog2(NW + 1);

   logic [NW-1:0] quo_q;
   logic [DW-1:0] rem_q;
   logic [DW-1:0] den_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          ready_q;
   logic [DW:0]   shifted;
   logic          fits;
   logic [DW:0]   diff;

   if (NW < 2 || DW < 1) begin : g_bad_w
      $error("srcal_div: widths too small");
   end

   assign shifted = {rem_q, quo_q[NW-1]};
   assign fits    = (shifted >= {1'b0, den_q});
   assign diff    = shifted - {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q   <= '0;
         rem_q   <= '0;
         den_q   <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         if (go_i) begin
            quo_q <= numer_i;
            rem_q <= '0;
            den_q <= denom_i;
            cnt_q <= CW'(NW);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? diff[DW-1:0] : shifted[DW-1:0];
            quo_q <= {quo_q[NW-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q   <= 1'b0;
               ready_q <= 1'b1;
            end
         end
      end
   end

   assign quo_o   = quo_q;
   assign ready_o = ready_q;

   AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (rem_q < den_q)); // R6

endmodule

// File: rtl/srcal_round.sv
module srcal_round #(
   parameter int unsigned QW       = 20,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned SCALE    = 1000,
   parameter int unsigned DEF_CODE = 4
) (
   input  logic [QW-1:0]     q_i,
   input  logic              zero_i,
   output logic [CODE_W-1:0] code_o
);
   localparam int unsigned MAXC = (1 << CODE_W) - 1;
   localparam int unsigned HALF = SCALE / 2;
   localparam int unsigned RW   = srcal_pkg::srcal_max(QW, $clog2(MAXC * SCALE + 1)) + 2;

   logic [MAXC-1:0] ge;
   logic [RW-1:0]   biased;
   logic [CODE_W:0] sum;

   if (DEF_CODE > MAXC) begin : g_bad_def
      $error("srcal_round: default code does not fit");
   end
   if (SCALE < 2) begin : g_bad_scale
      $error("srcal_round: SCALE must be at least 2");
   end

   assign biased = RW'(q_i) + RW'(HALF);

   for (genvar k = 1; k <= MAXC; k++) begin : g_thr
      assign ge[k-1] = (biased >= RW'(k * SCALE));
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < MAXC; i++) begin
         sum = sum + {{CODE_W{1'b0}}, ge[i]};
      end
      code_o = zero_i ? CODE_W'(DEF_CODE) : sum[CODE_W-1:0];
   end

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq #(
   parameter int unsigned PORT_W       = 2,
   parameter int unsigned CNT_W        = 24,
   parameter int unsigned WIN_W        = 24,
   parameter int unsigned CODE_W       = 3,
   parameter int unsigned WIN_CYC      = 1024,
   parameter int unsigned REF_MHZ      = 26,
   parameter int unsigned COEF_MILLI   = 28,
   parameter int unsigned SCALE        = 1000,
   parameter int unsigned DEF_CODE     = 4,
   parameter int unsigned OSC_WAIT_CYC = REF_MHZ,
   parameter int unsigned POLL_CYC     = 10 * REF_MHZ,
   parameter int unsigned TIMEOUT_CYC  = 200 * REF_MHZ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PORT_W-1:0] port_i,
   output logic              done_o,
   output logic              osc_en_o,
   output logic              frck_en_o,
   output logic              meter_en_o,
   output logic [WIN_W-1:0]  meter_win_o,
   output logic [PORT_W-1:0] meter_chan_o,
   input  logic              meter_valid_i,
   input  logic [CNT_W-1:0]  meter_count_i,
   output logic [CODE_W-1:0] code_o
);
   import srcal_pkg::*;

   localparam int unsigned NUMER = WIN_CYC * REF_MHZ * COEF_MILLI;
   localparam int unsigned QW    = $clog2(NUMER + 1);
   localparam int unsigned NPOLL = TIMEOUT_CYC / POLL_CYC;
   localparam int unsigned NP_W  = $clog2(NPOLL + 1);
   localparam int unsigned TMR_W = $clog2(srcal_max(OSC_WAIT_CYC, POLL_CYC) + 1);

   if (POLL_CYC < 1 || OSC_WAIT_CYC < 1) begin : g_bad_wait
      $error("srcal_seq: wait lengths must be nonzero");
   end
   if (NPOLL < 1) begin : g_bad_timeout
      $error("srcal_seq: timeout shorter than one poll interval");
   end
   if (WIN_CYC >= (1 << WIN_W)) begin : g_bad_win
      $error("srcal_seq: window does not fit its output");
   end
   if (QW > 31) begin : g_bad_numer
      $error("srcal_seq: numerator too wide");
   end

   srcal_st_e         st_q;
   logic [PORT_W-1:0] port_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [NP_W-1:0]   poll_q;
   logic              osc_q, frck_q, meter_q, done_q;
   logic [WIN_W-1:0]  win_q;
   logic [PORT_W-1:0] chan_q;
   logic [CODE_W-1:0] code_q;

   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_zero;
   logic              poll_last;
   logic              poll_take;
   logic              div_go;
   logic              div_ready;
   logic [QW-1:0]     quo;
   logic [CODE_W-1:0] rnd_code;
   logic              cnt_zero;

   assign cnt_zero  = (cnt_q == '0);
   assign poll_last = (poll_q == NP_W'(NPOLL - 1));
   assign poll_take = tmr_zero && (meter_valid_i || poll_last);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      div_go   = 1'b0;
      unique case (st_q)
         S_IDLE: if (start_i) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(OSC_WAIT_CYC);
         end
         S_ARM: begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POLL_CYC);
         end
         S_POLL: if (tmr_zero && !poll_take) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POLL_CYC);
         end
         S_FOFF: div_go = !cnt_zero;
         default: ;
      endcase
   end

   srcal_tmr #(.W(TMR_W)) i_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   srcal_div #(.NW(QW), .DW(CNT_W)) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (div_go),
      .numer_i (QW'(NUMER)),
      .denom_i (cnt_q),
      .quo_o   (quo),
      .ready_o (div_ready)
   );

   srcal_round #(
      .QW       (QW),
      .CODE_W   (CODE_W),
      .SCALE    (SCALE),
      .DEF_CODE (DEF_CODE)
   ) i_round (
      .q_i    (quo),
      .zero_i (cnt_zero),
      .code_o (rnd_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         port_q  <= '0;
         cnt_q   <= '0;
         poll_q  <= '0;
         osc_q   <= 1'b0;
         frck_q  <= 1'b0;
         meter_q <= 1'b0;
         done_q  <= 1'b0;
         win_q   <= '0;
         chan_q  <= '0;
         code_q  <= CODE_W'(DEF_CODE);
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            S_IDLE: if (start_i) begin
               port_q <= port_i;
               osc_q  <= 1'b1;
               st_q   <= S_OSCW;
            end
            S_OSCW: if (tmr_zero) begin
               frck_q <= 1'b1;
               st_q   <= S_PROG;
            end
            S_PROG: begin
               win_q  <= WIN_W'(WIN_CYC);
               chan_q <= port_q;
               st_q   <= S_ARM;
            end
            S_ARM: begin
               meter_q <= 1'b1;
               poll_q  <= '0;
               st_q    <= S_POLL;
            end
            S_POLL: if (tmr_zero) begin
               if (poll_take) begin
                  cnt_q <= meter_count_i;
                  st_q  <= S_MOFF;
               end else begin
                  poll_q <= poll_q + 1'b1;
               end
            end
            S_MOFF: begin
               meter_q <= 1'b0;
               st_q    <= S_FOFF;
            end
            S_FOFF: begin
               frck_q <= 1'b0;
               st_q   <= cnt_zero ? S_WRITE : S_DIV;
            end
            S_DIV: if (div_ready) st_q <= S_WRITE;
            S_WRITE: begin
               code_q <= rnd_code;
               st_q   <= S_OSCOFF;
            end
            S_OSCOFF: begin
               osc_q  <= 1'b0;
               done_q <= 1'b1;
               st_q   <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign done_o       = done_q;
   assign osc_en_o     = osc_q;
   assign frck_en_o    = frck_q;
   assign meter_en_o   = meter_q;
   assign meter_win_o  = win_q;
   assign meter_chan_o = chan_q;
   assign code_o       = code_q;

   AST_METER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      meter_q |-> (osc_q && frck_q)); // R2
   AST_METER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(meter_q) |-> (win_q == WIN_W'(WIN_CYC) && chan_q == port_q)); // R2
   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      meter_q |-> (poll_q < NP_W'(NPOLL))); // R4
   AST_FRCK_OUTLIVES: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(meter_q) |-> frck_q); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R9
   AST_DONE_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!osc_q && $past(osc_q))); // R9
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_WRITE) |=> $stable(code_q)); // R10

endmodule

// File: tb/test_srcal_seq.sv
module test_srcal_seq;

   localparam int unsigned PW   = 2;
   localparam int unsigned CW   = 24;
   localparam int unsigned OSCW = 6;
   localparam int unsigned POLL = 10;
   localparam int unsigned TOUT = 50;
   localparam int unsigned NP   = TOUT / POLL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [PW-1:0] port_i = '0;
   logic          done_o, osc_en_o, frck_en_o, meter_en_o;
   logic [23:0]   meter_win_o;
   logic [PW-1:0] meter_chan_o;
   logic          meter_valid_i = 1'b0;
   logic [CW-1:0] meter_count_i = '0;
   logic [2:0]    code_o;

   int checks = 0;
   int errors = 0;

   int lat_cfg = 5;
   bit never_cfg = 1'b0;
   int lat_cnt = 0;

   int  cyc = 0;
   bit  p_osc, p_frck, p_meter;
   int  osc_pre, osc_gap;
   int  meter_dur;
   logic [PW-1:0] chan_arm;
   logic [23:0]   win_arm;
   int  cyc_mfall, cyc_ffall;
   int  gate_bad = 0;
   int  done_total = 0;
   int  cyc_done;

   always #10 clk = ~clk;

   srcal_seq #(
      .OSC_WAIT_CYC (OSCW),
      .POLL_CYC     (POLL),
      .TIMEOUT_CYC  (TOUT)
   ) i_srcal_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .port_i        (port_i),
      .done_o        (done_o),
      .osc_en_o      (osc_en_o),
      .frck_en_o     (frck_en_o),
      .meter_en_o    (meter_en_o),
      .meter_win_o   (meter_win_o),
      .meter_chan_o  (meter_chan_o),
      .meter_valid_i (meter_valid_i),
      .meter_count_i (meter_count_i),
      .code_o        (code_o)
   );

   // meter model and monitor, both on the falling edge
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (!meter_en_o) begin
         meter_valid_i <= 1'b0;
         lat_cnt       <= 0;
      end else begin
         lat_cnt <= lat_cnt + 1;
         if (!never_cfg && lat_cnt + 1 >= lat_cfg) meter_valid_i <= 1'b1;
      end
      if (osc_en_o && !p_osc) begin
         osc_pre   <= 1;
         meter_dur <= 0;
      end else if (osc_en_o && !frck_en_o && !p_frck) begin
         osc_pre <= osc_pre + 1;
      end
      if (frck_en_o && !p_frck) osc_gap <= osc_pre;
      if (meter_en_o && !p_meter) begin
         chan_arm <= meter_chan_o;
         win_arm  <= meter_win_o;
      end
      if (meter_en_o) meter_dur <= (p_meter ? meter_dur : 0) + 1;
      if (!meter_en_o && p_meter) cyc_mfall <= cyc;
      if (!frck_en_o && p_frck) cyc_ffall <= cyc;
      if (meter_en_o && !(osc_en_o && frck_en_o)) gate_bad <= gate_bad + 1;
      if (done_o) begin
         done_total <= done_total + 1;
         cyc_done   <= cyc;
      end
      p_osc   <= osc_en_o;
      p_frck  <= frck_en_o;
      p_meter <= meter_en_o;
   end

   function automatic int exp_code(input int unsigned c);
      int unsigned q, r;
      if (c == 0) return 4;
      q = 745472 / c;
      r = (q + 500) / 1000;
      return (r > 7) ? 7 : int'(r);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic run_cal(input int port, input int unsigned cnt, input int lat,
                          input bit never, input bit poke, input string tag);
      int d0;
      int w;
      bit seen;
      d0 = done_total;
      @(negedge clk);
      lat_cfg       = lat;
      never_cfg     = never;
      meter_count_i = CW'(cnt);
      port_i        = PW'(port);
      start_i       = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 3000 && !seen; i++) begin
         @(negedge clk);
         if (poke && i == 20) begin
            port_i  = ~PW'(port);
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         if (done_o) seen = 1'b1;
      end
      start_i = 1'b0;
      check(seen, "R9 done seen", int'(seen), 1);
      w = 0;
      repeat (12) begin
         @(negedge clk);
         if (osc_en_o) w++;
      end
      check(done_total - d0 == 1, "R9 one done per run", done_total - d0, 1);
      check(w == 0, "R9 no restart after done", w, 0);
      check(code_o == 3'(exp_code(cnt)), tag, int'(code_o), exp_code(cnt));
      check(osc_gap >= OSCW, "R2 oscillator settle", osc_gap, OSCW);
      check(int'(chan_arm) == port && win_arm == 24'd1024, "R2 channel/window",
            int'(chan_arm), port);
      check(cyc_mfall < cyc_ffall && cyc_ffall < cyc_done, "R5 shutdown order",
            cyc_ffall - cyc_mfall, 1);
      if (never)
         check(meter_dur >= NP * POLL && meter_dur <= NP * (POLL + 1) + 3,
               "R4 timeout length", meter_dur, NP * POLL);
      else
         check(meter_dur >= lat && meter_dur <= lat + POLL + 4,
               "R3 poll catches valid", meter_dur, lat);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
   end

   initial begin
      logic [2:0] held;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!osc_en_o && !frck_en_o && !meter_en_o && !done_o, "R1 enables low",
            int'({osc_en_o, frck_en_o, meter_en_o, done_o}), 0);
      check(code_o == 3'd4, "R1 reset code", int'(code_o), 4);

      run_cal(1, 1490, 7,  1'b0, 1'b0, "R6 half rounds up");
      run_cal(2, 1491, 3,  1'b0, 1'b0, "R6 below half rounds down");
      run_cal(0, 745,  12, 1'b0, 1'b0, "R6 exact thousand");
      run_cal(3, 2666, 25, 1'b0, 1'b0, "R6 small code");
      run_cal(1, 0,    4,  1'b0, 1'b0, "R7 zero count default");
      run_cal(2, 1,    2,  1'b0, 1'b0, "R8 clamp at seven");
      run_cal(0, 93,   9,  1'b0, 1'b0, "R8 code eight clamps");
      run_cal(3, 212,  1,  1'b1, 1'b0, "R4 timeout uses present count");
      run_cal(1, 0,    1,  1'b1, 1'b0, "R4 R7 timeout zero count");
      run_cal(2, 350,  30, 1'b0, 1'b1, "R9 start ignored mid-run");

      held = code_o;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         meter_count_i = CW'($urandom);
         meter_valid_i = 1'b1;
      end
      @(negedge clk);
      check(code_o == held, "R10 code holds between runs", int'(code_o), int'(held));

      for (int n = 0; n < 20; n++) begin
         int unsigned c;
         int sel;
         sel = int'($urandom_range(0, 3));
         if (sel == 0)      c = $urandom_range(1, 200);
         else if (sel == 1) c = $urandom_range(200, 3000);
         else if (sel == 2) c = $urandom_range(3000, 1000000);
         else               c = $urandom_range(0, 3);
         run_cal(int'($urandom_range(0, 3)), c, int'($urandom_range(1, 45)),
                 ($urandom_range(0, 7) == 0), 1'b0, "R6 random count");
      end

      check(gate_bad == 0, "R2 meter only under both enables", gate_bad, 0);
      summary();
   end

endmodule